// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and a byte-wide asynchronous static RAM with a 19-bit address and an 8-bit data bus. It takes single-beat read and write requests and plays them out as chip-enable, output-enable and write-enable strobes. Every strobe interval lasts a whole number of system clock cycles. Each count is derived at elaboration time from a nanosecond timing parameter and the clock period. The data bus is driven through a separate output value and an explicit driver-enable, so that the pad ring can build the tri-state buffer.

Requests enter over a valid/ready channel. The sequencer accepts a request only when it is idle. A host that keeps `req_valid` high is stalled until the previous access, including its recovery or turnaround time, has finished. Read data leaves over a second valid/ready channel. While a read response waits for `rsp_ready`, the data stays frozen and no new request is accepted, so one unclaimed response back-pressures the request side. Writes produce no response.

A parameter chooses which strobe ends a write. With `CE_TERM = 0`, write enable rises first. With `CE_TERM = 1`, chip enable rises first. Each choice carries its own data-hold and recovery times.

Top module: `sram_seq`

## Requirements
- R1: After reset and whenever the block is idle, chip enable, output enable and write enable are high, the data driver is off, `req_ready` is 1, `busy` is 0 and `rsp_valid` is 0.
- R2: Every interval count equals the nanosecond value divided by `CLK_NS`, rounded up, with a floor of one cycle.
- R3: A read holds chip enable and output enable low and write enable high for exactly max(access, chip-enable access, output-enable access, read cycle) cycles. The bus value sampled on the last of those cycles is returned on `rsp_data`.
- R4: After a read, all three strobes stay high for at least the output-release count before any strobe falls again.
- R5: A write holds chip enable and write enable both low for exactly max(write pulse, data setup) cycles. `sram_addr` does not change while any strobe is low.
- R6: With `CE_TERM = 0`, chip enable falls one setup count before write enable, write enable rises first while chip enable is still low, and the data driver stays on for the write-enable hold count after that edge.
- R7: With `CE_TERM = 1`, write enable falls one setup count before chip enable, chip enable rises first while write enable is still low, and the data driver stays on for the chip-enable hold count after that edge.
- R8: Output enable is high whenever write enable is low or the data driver is on. The driver switches on only in a cycle where write enable and chip enable are both low, and it switches off in the cycle after the hold count ends.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `busy` is 1 and `req_ready` is 0 from the cycle after acceptance until the access and its recovery are complete.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` holds its value, `req_ready` stays 0 and no strobe falls. `rsp_valid` clears on the edge that completes the handshake.
- R11: A write never raises `rsp_valid`.
- R12: After the pulse and hold of a write, all strobes stay high for at least max(recovery count for the selected ending, write cycle count minus setup, pulse and hold counts).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | DW | Read data |
| busy | output | 1 | Access or recovery in progress |
| sram_addr | output | AW | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | DW | Value for the data pads |
| sram_dq_oe | output | 1 | Data pad driver enable |
| sram_dq_in | input | DW | Value read from the data pads |

## Verification
The bench drives a memory model that returns a filler byte until the strobes have been held low for the full access count. A read cut one cycle short therefore returns wrong data, and the mismatch shows at the response. A monitor measures each pulse, hold and idle gap in cycles, and checks which strobe rises first under both write-ending choices. An off-by-one count or swapped strobes would show as a wrong width or a reversed edge order. Reads are made to wait on a stalled response while a second request is pending. A sequencer that let the request through would start a strobe or change the held data. Writes to the all-zero and all-one addresses, followed by read-back, expose address truncation and data-latch errors.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RHZ,
    ST_RSPW,
    ST_WSU,
    ST_WPL,
    ST_WHD,
    ST_WREC
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STRB_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  // Whole clock cycles covering a delay, never fewer than one.
  function automatic int ns2cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int CE_TERM = 0,
  parameter int N_RD    = 7,
  parameter int N_HZ    = 3,
  parameter int N_AS    = 1,
  parameter int N_PW    = 6,
  parameter int N_DH    = 1,
  parameter int N_REC   = 1,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          rsp_valid,
  input  logic          rsp_ready,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          cap_en,
  output logic          req_ready,
  output logic          busy,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe
);

  seq_state_e st_q, st_nx;
  strobe_t    strb_q, strb_nx;
  strobe_t    su_strb, hd_strb;

  // The selected write ending decides which strobe leads in the setup and
  // which one is left low during the data hold.
  if (CE_TERM != 0) begin : g_ce_end
    assign su_strb = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b0};
    assign hd_strb = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
  end else begin : g_we_end
    assign su_strb = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    assign hd_strb = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
  end

  function automatic int dur(input seq_state_e s);
    case (s)
      ST_RD:   return N_RD;
      ST_RHZ:  return N_HZ;
      ST_WSU:  return N_AS;
      ST_WPL:  return N_PW;
      ST_WHD:  return N_DH;
      ST_WREC: return N_REC;
      default: return 1;
    endcase
  endfunction

  always_comb begin
    st_nx  = st_q;
    accept = 1'b0;
    cap_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          st_nx  = req_write ? ST_WSU : ST_RD;
        end
      end
      ST_RD: begin
        if (tmr_zero) begin
          cap_en = 1'b1;
          st_nx  = ST_RHZ;
        end
      end
      ST_RHZ: begin
        if (tmr_zero) st_nx = (rsp_valid && !rsp_ready) ? ST_RSPW : ST_IDLE;
      end
      ST_RSPW: begin
        if (!rsp_valid || rsp_ready) st_nx = ST_IDLE;
      end
      ST_WSU:  if (tmr_zero) st_nx = ST_WPL;
      ST_WPL:  if (tmr_zero) st_nx = ST_WHD;
      ST_WHD:  if (tmr_zero) st_nx = ST_WREC;
      ST_WREC: if (tmr_zero) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign tmr_load = (st_nx != st_q);
  assign tmr_val  = CW'(dur(st_nx) - 1);

  // Strobes are decoded from the next state and registered, so the pins
  // switch on the same edge as the state and never glitch.
  always_comb begin
    case (st_nx)
      ST_RD:   strb_nx = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
      ST_WSU:  strb_nx = su_strb;
      ST_WPL:  strb_nx = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
      ST_WHD:  strb_nx = hd_strb;
      default: strb_nx = STRB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      strb_q <= STRB_IDLE;
    end else begin
      st_q   <= st_nx;
      strb_q <= strb_nx;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign ce_n      = strb_q.ce_n;
  assign oe_n      = strb_q.oe_n;
  assign we_n      = strb_q.we_n;
  assign dq_oe     = strb_q.dq_oe;

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cap_en,
  input  logic [DW-1:0] sram_dq_in,
  input  logic          rsp_ready,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] rd_q;
  logic          vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wd_q   <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else if (cap_en) begin
      rd_q  <= sram_dq_in;
      vld_q <= 1'b1;
    end else if (vld_q && rsp_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign sram_addr   = addr_q;
  assign sram_dq_out = wd_q;
  assign rsp_valid   = vld_q;
  assign rsp_data    = rd_q;

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int CE_TERM    = 0,
  parameter int T_RC_NS    = 70,
  parameter int T_ACC_NS   = 70,
  parameter int T_CO_NS    = 70,
  parameter int T_OE_NS    = 35,
  parameter int T_HZ_NS    = 25,
  parameter int T_WC_NS    = 70,
  parameter int T_WP_NS    = 55,
  parameter int T_AS_NS    = 0,
  parameter int T_DS_NS    = 30,
  parameter int T_WR_WE_NS = 5,
  parameter int T_DH_WE_NS = 0,
  parameter int T_WR_CE_NS = 15,
  parameter int T_DH_CE_NS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);

  localparam int N_RD  = imax(imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_CO_NS, CLK_NS)),
                              imax(ns2cyc(T_OE_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS)));
  localparam int N_HZ  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int N_AS  = ns2cyc(T_AS_NS, CLK_NS);
  localparam int N_PW  = imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
  localparam int N_DH  = ns2cyc((CE_TERM != 0) ? T_DH_CE_NS : T_DH_WE_NS, CLK_NS);
  localparam int N_WR  = ns2cyc((CE_TERM != 0) ? T_WR_CE_NS : T_WR_WE_NS, CLK_NS);
  localparam int N_WC  = ns2cyc(T_WC_NS, CLK_NS);
  localparam int N_REC = imax(N_WR, N_WC - (N_AS + N_PW + N_DH));
  localparam int N_MAX = imax(imax(imax(N_RD, N_HZ), imax(N_AS, N_PW)), imax(N_DH, N_REC));
  localparam int CW    = $clog2(N_MAX + 1);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          accept;
  logic          cap_en;

  sram_seq_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_ctrl #(
    .CE_TERM (CE_TERM),
    .N_RD    (N_RD),
    .N_HZ    (N_HZ),
    .N_AS    (N_AS),
    .N_PW    (N_PW),
    .N_DH    (N_DH),
    .N_REC   (N_REC),
    .CW      (CW)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .cap_en    (cap_en),
    .req_ready (req_ready),
    .busy      (busy),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .dq_oe     (sram_dq_oe)
  );

  sram_seq_dpath #(.AW(AW), .DW(DW)) i_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .cap_en      (cap_en),
    .sram_dq_in  (sram_dq_in),
    .rsp_ready   (rsp_ready),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce_n,
  input logic          sram_oe_n,
  input logic          sram_we_n,
  input logic          sram_dq_oe
);

  // R8
  oe_high_when_we_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  // R8
  drive_needs_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  // R8
  drive_starts_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (!sram_we_n && !sram_ce_n));

  // R5
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!sram_ce_n || !sram_we_n) && $past(!sram_ce_n || !sram_we_n)) |-> $stable(sram_addr));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10
  no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (sram_ce_n && sram_we_n));

endmodule

bind sram_seq sram_seq_chk #(.AW(AW), .DW(DW)) i_sram_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_sram_seq.sv
`timescale 1ns/1ps
module test_sram_seq;

  localparam int TCK = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + TCK - 1) / TCK;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected counts from the requirements at a 10 ns clock (R2)
  localparam int E_ACC = mx(mx(cyc(70), cyc(70)), cyc(35));
  localparam int E_RD  = mx(E_ACC, cyc(70));
  localparam int E_HZ  = cyc(25);
  localparam int E_AS  = cyc(0);
  localparam int E_PW  = mx(cyc(55), cyc(30));
  localparam int E_WC  = cyc(70);

  function automatic int e_dh(input int g);
    return (g != 0) ? cyc(10) : cyc(0);
  endfunction

  function automatic int e_rec(input int g);
    int wr;
    wr = (g != 0) ? cyc(15) : cyc(5);
    return mx(wr, E_WC - (E_AS + E_PW + e_dh(g)));
  endfunction

  function automatic logic [18:0] amap(input int idx);
    logic [12:0] hi;
    hi = 13'(idx * 97 + 5);
    if (idx == 0)  return 19'h00000;
    if (idx == 63) return 19'h7FFFF;
    return {hi, 6'(idx)};
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  bit   run = 1'b0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #(TCK / 2) clk = ~clk;

  logic        req_valid [2];
  logic        req_write [2];
  logic [18:0] req_addr  [2];
  logic [7:0]  req_wdata [2];
  logic        rsp_ready [2];
  logic        req_ready [2];
  logic        rsp_valid [2];
  logic [7:0]  rsp_data  [2];
  logic        busy      [2];
  logic [18:0] sram_addr [2];
  logic        ce_n      [2];
  logic        oe_n      [2];
  logic        we_n      [2];
  logic [7:0]  dq_out    [2];
  logic        dq_oe     [2];
  logic [7:0]  exp_mem   [2][64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  for (genvar g = 0; g < 2; g++) begin : g_dut
    logic [7:0] m_dq;
    logic [7:0] mem [64];
    int  m_cnt = 0;
    int  pcnt = 0, rcnt = 0, hcnt = 0, icnt = 0, ocnt = 0;
    bit  hold_on = 0, last_wr = 0, seen_op = 0;

    sram_seq #(.CE_TERM(g)) i_sram_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid[g]),
      .req_ready   (req_ready[g]),
      .req_write   (req_write[g]),
      .req_addr    (req_addr[g]),
      .req_wdata   (req_wdata[g]),
      .rsp_valid   (rsp_valid[g]),
      .rsp_ready   (rsp_ready[g]),
      .rsp_data    (rsp_data[g]),
      .busy        (busy[g]),
      .sram_addr   (sram_addr[g]),
      .sram_ce_n   (ce_n[g]),
      .sram_oe_n   (oe_n[g]),
      .sram_we_n   (we_n[g]),
      .sram_dq_out (dq_out[g]),
      .sram_dq_oe  (dq_oe[g]),
      .sram_dq_in  (m_dq)
    );

    initial begin
      m_dq = 8'h5A;
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    end

    // Memory model plus strobe-timing monitor, sampled on falling edges
    always @(negedge clk) begin
      if (run) begin
        automatic bit pulse = !ce_n[g] && !we_n[g];
        automatic bit rd    = !ce_n[g] && !oe_n[g] && we_n[g];
        automatic bit idle  = ce_n[g] && we_n[g] && oe_n[g];

        if (!idle && icnt > 0 && seen_op) begin
          // R4 / R12: idle gap after the previous access
          if (last_wr) begin
            chk(icnt >= e_rec(g), "R12 write recovery", icnt, e_rec(g));
            chk(ocnt + icnt >= E_WC, "R12 write cycle span", ocnt + icnt, E_WC);
          end else begin
            chk(icnt >= E_HZ, "R4 read turnaround", icnt, E_HZ);
          end
        end
        if (!idle) begin
          if (icnt > 0) ocnt = 0;
          ocnt++;
          icnt = 0;
          seen_op = 1;
        end else begin
          icnt++;
        end

        if (pulse) begin
          pcnt++;
        end else if (pcnt > 0) begin
          chk(pcnt == E_PW, "R5 write pulse width", pcnt, E_PW);
          chk(sram_addr[g] == amap(int'(sram_addr[g][5:0])), "R5 write address",
              int'(sram_addr[g]), int'(amap(int'(sram_addr[g][5:0]))));
          if (g == 0)
            chk(we_n[g] && !ce_n[g], "R6 WE rises first", {30'd0, ce_n[g], we_n[g]}, 1);
          else
            chk(ce_n[g] && !we_n[g], "R7 CE rises first", {30'd0, ce_n[g], we_n[g]}, 2);
          mem[sram_addr[g][5:0]] = dq_oe[g] ? dq_out[g] : 8'hEE;
          pcnt = 0;
          hold_on = 1;
          hcnt = 0;
          last_wr = 1;
        end
        if (hold_on) begin
          if (dq_oe[g]) hcnt++;
          else begin
            chk(hcnt == e_dh(g), (g == 0) ? "R6 data hold" : "R7 data hold", hcnt, e_dh(g));
            chk(hcnt == e_dh(g), "R8 driver release", hcnt, e_dh(g));
            hold_on = 0;
          end
        end

        if (rd) begin
          rcnt++;
        end else if (rcnt > 0) begin
          chk(rcnt == E_RD, "R3 read strobe width", rcnt, E_RD);
          rcnt = 0;
          last_wr = 0;
        end

        if (rd) m_cnt++;
        else m_cnt = 0;
        m_dq = (rd && m_cnt >= E_ACC) ? mem[sram_addr[g][5:0]] : 8'h5A;
      end
    end
  end

  task automatic send(input int g, input bit wr, input int idx, input logic [7:0] d);
    @(negedge clk);
    req_valid[g] = 1'b1;
    req_write[g] = wr;
    req_addr[g]  = amap(idx);
    req_wdata[g] = d;
    while (!req_ready[g]) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid[g] = 1'b0;
    chk(busy[g] && !req_ready[g], "R9 busy after accept", {30'd0, busy[g], req_ready[g]}, 2);
  endtask

  task automatic do_write(input int g, input int idx, input logic [7:0] d);
    send(g, 1'b1, idx, d);
    exp_mem[g][idx] = d;
    chk(!rsp_valid[g], "R11 no write response", int'(rsp_valid[g]), 0);
  endtask

  task automatic do_read(input int g, input int idx, input int dly, input bit probe);
    logic [7:0] first;
    send(g, 1'b0, idx, 8'h00);
    while (!rsp_valid[g]) @(negedge clk);
    first = rsp_data[g];
    if (probe) begin
      req_valid[g] = 1'b1;
      req_write[g] = 1'b1;
      req_addr[g]  = amap(5);
      req_wdata[g] = 8'h99;
    end
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(rsp_valid[g] && rsp_data[g] == first, "R10 response held",
          int'(rsp_data[g]), int'(first));
      chk(!req_ready[g], "R10 request blocked", int'(req_ready[g]), 0);
      if (probe)
        chk(ce_n[g] && we_n[g] && oe_n[g], "R10 no strobe while pending",
            {29'd0, ce_n[g], we_n[g], oe_n[g]}, 7);
    end
    req_valid[g] = 1'b0;
    chk(first == exp_mem[g][idx], "R3 read data", int'(first), int'(exp_mem[g][idx]));
    rsp_ready[g] = 1'b1;
    @(negedge clk);
    rsp_ready[g] = 1'b0;
    chk(!rsp_valid[g], "R10 handshake clears", int'(rsp_valid[g]), 0);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int g = 0; g < 2; g++) begin
      req_valid[g] = 1'b0;
      req_write[g] = 1'b0;
      req_addr[g]  = '0;
      req_wdata[g] = '0;
      rsp_ready[g] = 1'b0;
      for (int i = 0; i < 64; i++) exp_mem[g][i] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;
    for (int g = 0; g < 2; g++)
      chk({ce_n[g], oe_n[g], we_n[g], dq_oe[g], req_ready[g], busy[g], rsp_valid[g]} == 7'b1110100,
          "R1 reset state",
          int'({ce_n[g], oe_n[g], we_n[g], dq_oe[g], req_ready[g], busy[g], rsp_valid[g]}),
          int'(7'b1110100));

    for (int g = 0; g < 2; g++) begin
      // Directed corners: lowest and highest address, back-to-back writes
      do_write(g, 0, 8'h3C);
      do_write(g, 63, 8'hC3);
      do_read(g, 0, 0, 0);
      do_read(g, 63, 0, 0);
      do_write(g, 17, 8'hFF);
      do_write(g, 17, 8'h01);
      do_read(g, 17, 5, 1);
      do_read(g, 63, 2, 0);
      repeat (20) @(negedge clk);
      chk(req_ready[g] && !busy[g], "R1 idle again", int'(req_ready[g]), 1);
      // Random mix
      for (int i = 0; i < 120; i++) begin
        automatic int idx = $urandom_range(63);
        if ($urandom_range(1) == 1) do_write(g, idx, 8'($urandom));
        else do_read(g, idx, $urandom_range(3), ($urandom_range(7) == 0));
        repeat ($urandom_range(2)) @(negedge clk);
      end
      repeat (20) @(negedge clk);
    end
    finish_up();
  end

endmodule